// File: doc/BRIEF.md
# Output Short-Circuit Retry Controller

This block applies a retry policy to the output stages of a multi-channel headphone driver. It keeps one independent controller per audio channel. Each controller watches a short-circuit detect input that the output stage drives. When a short is seen on a powered, enabled channel, the controller removes power from that channel's output stage for a fixed wait time and then restores it. Restoring power opens a re-check window. A short detected inside that window counts as a repeat of the previous one. If the window closes with no further short, the repeat count returns to zero.

When a channel reaches the strike limit (three by default), it enters a latched fault. Its short-circuit flag and its high-impedance flag both go high, and its output stage stays unpowered. Register reads have no effect on this state. Only the clear pulse, which the register bank raises on any write to its first control register, releases the fault. The pulse also clears the strike count and powers the stage again.

The wait time, the window length, the strike limit and the channel count are parameters. The wait and the window are given in clock cycles.

Top module: `sc_retry_bank`

## Requirements
- R1: While reset is asserted, every channel has `sc_flag` = 0 and `hiz_flag` = 0, and `pwr_on` equals that channel's `ch_enable` bit. Bit i of every vector port belongs to channel i.
- R2: A `short_det` high while the channel is powered and enabled drops `pwr_on` on the next clock edge. `pwr_on` then stays low for exactly `WAIT_CYC` cycles and rises again with no further stimulus.
- R3: Once power is restored, a detection in any of the next `WIN_CYC` cycles counts as a repeat strike. This includes a detection in the last cycle of that window.
- R4: If the `WIN_CYC` cycles after power is restored pass with no detection, the strike count returns to zero. A later detection then counts as the first strike.
- R5: The detection that brings the strike count to `STRIKES` sets `sc_flag` and `hiz_flag` of that channel on the next edge and drops `pwr_on` there. A flag rises only after a detection on its own channel.
- R6: A latched fault holds both flags high and `pwr_on` low for any length of time, whatever `short_det` does. Only a `fault_clr` pulse releases it, and that pulse also zeroes the strike count.
- R7: Detections while a channel is in its power-off wait are ignored. They do not lengthen the wait and do not add strikes.
- R8: While `ch_enable` of a channel is low, its `pwr_on` is low and its detections are ignored. They add no strikes.
- R9: When `fault_clr` and a detection are present in the same cycle, the clear wins. The channel ends up powered, with zero strikes and both flags low.
- R10: Channels are independent. Strikes, waits and faults on one channel never change the outputs of another.
- R11: A detection on a powered channel with no re-check window open counts as strike one and starts the same power-off wait as any other strike.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_enable | input | NUM_CH | Per-channel enable from the control register |
| short_det | input | NUM_CH | Per-channel short-circuit detect from the output stage |
| fault_clr | input | 1 | One-cycle clear pulse, raised on a write to control register 1 |
| pwr_on | output | NUM_CH | Per-channel output stage power request |
| sc_flag | output | NUM_CH | Per-channel latched short-circuit flag |
| hiz_flag | output | NUM_CH | Per-channel latched high-impedance flag |

## Verification
The bench builds the block with two channels, a 5-cycle wait, an 8-cycle window and the default strike limit of three. Cutting the 40 ms durations down to a few cycles brings a wide range of behaviour into a short run. It can check the exact power-off length and the detection in the last window cycle against the one just after expiry. It can also run repeated three-strike sequences with resets of the count in between, and faults on one channel while the other keeps retrying. Two channels are enough to show that strikes and faults stay confined to their own channel.

// File: rtl/sc_retry_pkg.sv
package sc_retry_pkg;

   // Per-channel controller state
   typedef enum logic [1:0] {
      CH_RUN    = 2'd0,  // powered, no re-check window open
      CH_WAIT   = 2'd1,  // powered off after a strike
      CH_WINDOW = 2'd2,  // powered, re-check window open
      CH_FAULT  = 2'd3   // latched fault, output held high impedance
   } ch_state_e;

   // Width able to hold values 0 .. v-1, at least one bit
   function automatic int unsigned idx_width(input int unsigned v);
      return (v > 1) ? $clog2(v) : 1;
   endfunction

endpackage

// File: rtl/sc_wait_timer.sv
module sc_wait_timer #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/sc_strike_ctr.sv
module sc_strike_ctr #(
   parameter int unsigned STRIKES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic at_last
);

   localparam int unsigned CW = $clog2(STRIKES + 1);
   localparam logic [CW-1:0] LAST_VAL = CW'(STRIKES - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (inc) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // The next strike is the one that latches the fault
   assign at_last = (cnt_q == LAST_VAL);

endmodule

// File: rtl/sc_retry_chan.sv
module sc_retry_chan
   import sc_retry_pkg::*;
#(
   parameter int unsigned WAIT_CYC = 16,
   parameter int unsigned WIN_CYC  = 16,
   parameter int unsigned STRIKES  = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic short_det,
   input  logic clr,
   output logic pwr_on,
   output logic fault
);

   localparam int unsigned MAX_CYC = (WAIT_CYC > WIN_CYC) ? WAIT_CYC : WIN_CYC;
   localparam int unsigned TW      = idx_width(MAX_CYC);
   localparam logic [TW-1:0] WAIT_LD = TW'(WAIT_CYC - 1);
   localparam logic [TW-1:0] WIN_LD  = TW'(WIN_CYC - 1);

   ch_state_e       state_q, state_d;
   logic            powered;
   logic            det_ok;
   logic            t_load;
   logic [TW-1:0]   t_val;
   logic            t_expired;
   logic            s_inc;
   logic            s_clr;
   logic            s_last;

   assign powered = (state_q == CH_RUN) || (state_q == CH_WINDOW);
   assign det_ok  = enable && powered && short_det;

   always_comb begin
      state_d = state_q;
      t_load  = 1'b0;
      t_val   = '0;
      s_inc   = 1'b0;
      s_clr   = 1'b0;
      if (clr) begin
         // clear from the register write beats any detection
         state_d = CH_RUN;
         s_clr   = 1'b1;
      end else begin
         unique case (state_q)
            CH_RUN, CH_WINDOW: begin
               if (det_ok) begin
                  s_inc = 1'b1;
                  if (s_last) begin
                     state_d = CH_FAULT;
                  end else begin
                     state_d = CH_WAIT;
                     t_load  = 1'b1;
                     t_val   = WAIT_LD;
                  end
               end else if ((state_q == CH_WINDOW) && t_expired) begin
                  state_d = CH_RUN;
                  s_clr   = 1'b1;
               end
            end
            CH_WAIT: begin
               if (t_expired) begin
                  state_d = CH_WINDOW;
                  t_load  = 1'b1;
                  t_val   = WIN_LD;
               end
            end
            CH_FAULT: begin
               state_d = CH_FAULT;
            end
            default: state_d = CH_RUN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= CH_RUN;
      end else begin
         state_q <= state_d;
      end
   end

   sc_wait_timer #(
      .CNT_W (TW)
   ) timer_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .expired  (t_expired)
   );

   sc_strike_ctr #(
      .STRIKES (STRIKES)
   ) strikes_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (s_clr),
      .inc     (s_inc),
      .at_last (s_last)
   );

   assign pwr_on = enable && powered;
   assign fault  = (state_q == CH_FAULT);

endmodule

// File: rtl/sc_retry_bank.sv
module sc_retry_bank #(
   parameter int unsigned NUM_CH   = 2,
   parameter int unsigned WAIT_CYC = 4_000_000,
   parameter int unsigned WIN_CYC  = 4_000_000,
   parameter int unsigned STRIKES  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] ch_enable,
   input  logic [NUM_CH-1:0] short_det,
   input  logic              fault_clr,
   output logic [NUM_CH-1:0] pwr_on,
   output logic [NUM_CH-1:0] sc_flag,
   output logic [NUM_CH-1:0] hiz_flag
);

   // Elaboration-time parameter checks
   if (NUM_CH < 1) begin : g_bad_nch
      $error("sc_retry_bank: NUM_CH must be at least 1");
   end
   if (WAIT_CYC < 1) begin : g_bad_wait
      $error("sc_retry_bank: WAIT_CYC must be at least 1");
   end
   if (WIN_CYC < 1) begin : g_bad_win
      $error("sc_retry_bank: WIN_CYC must be at least 1");
   end
   if (STRIKES < 1) begin : g_bad_strk
      $error("sc_retry_bank: STRIKES must be at least 1");
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic fault_c;

      sc_retry_chan #(
         .WAIT_CYC (WAIT_CYC),
         .WIN_CYC  (WIN_CYC),
         .STRIKES  (STRIKES)
      ) chan_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .enable    (ch_enable[c]),
         .short_det (short_det[c]),
         .clr       (fault_clr),
         .pwr_on    (pwr_on[c]),
         .fault     (fault_c)
      );

      assign sc_flag[c]  = fault_c;
      assign hiz_flag[c] = fault_c;
   end

endmodule

// File: rtl/sc_retry_chk.sv
module sc_retry_chk #(
   parameter int unsigned NUM_CH = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_CH-1:0] ch_enable,
   input logic [NUM_CH-1:0] short_det,
   input logic              fault_clr,
   input logic [NUM_CH-1:0] pwr_on,
   input logic [NUM_CH-1:0] sc_flag,
   input logic [NUM_CH-1:0] hiz_flag
);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
      assert_off_after_detect_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (ch_enable[c] && pwr_on[c] && short_det[c] && !fault_clr) |=> !pwr_on[c])
         else $error("R2: channel %0d still powered after a detection", c);

      assert_fault_unpowered_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (sc_flag[c] || hiz_flag[c]) |-> !pwr_on[c])
         else $error("R5: channel %0d powered while faulted", c);

      assert_flag_rise_needs_detect_R5: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(sc_flag[c]) |-> $past(short_det[c]))
         else $error("R5: channel %0d flag rose without a detection", c);

      assert_flag_fall_needs_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(hiz_flag[c]) |-> $past(fault_clr))
         else $error("R6: channel %0d flag fell without a clear", c);

      assert_disabled_unpowered_R8: assert property (@(posedge clk) disable iff (!rst_n)
         !ch_enable[c] |-> !pwr_on[c])
         else $error("R8: channel %0d powered while disabled", c);

      assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
         fault_clr |=> (!sc_flag[c] && !hiz_flag[c] && (pwr_on[c] || !ch_enable[c])))
         else $error("R9: channel %0d not restored by clear", c);
   end

endmodule

bind sc_retry_bank sc_retry_chk #(
   .NUM_CH (NUM_CH)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .ch_enable (ch_enable),
   .short_det (short_det),
   .fault_clr (fault_clr),
   .pwr_on    (pwr_on),
   .sc_flag   (sc_flag),
   .hiz_flag  (hiz_flag)
);

// File: tb/sc_retry_bank_tb_top.sv
`timescale 1ns/1ps
module sc_retry_bank_tb_top;

   localparam int unsigned W = 5;
   localparam int unsigned N = 8;

   typedef struct {
      logic [1:0] pwr;
      logic [1:0] flg;
      string      tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] ch_en = 2'b11;
   logic [1:0] det_i = 2'b00;
   logic       clr_i = 1'b0;
   logic [1:0] pwr_on, sc_flag, hiz_flag;

   int   n_chk = 0;
   int   n_err = 0;
   bit   done  = 1'b0;
   exp_t q[$];

   always #5 clk = ~clk;

   sc_retry_bank #(
      .NUM_CH   (2),
      .WAIT_CYC (W),
      .WIN_CYC  (N),
      .STRIKES  (3)
   ) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .ch_enable (ch_en),
      .short_det (det_i),
      .fault_clr (clr_i),
      .pwr_on    (pwr_on),
      .sc_flag   (sc_flag),
      .hiz_flag  (hiz_flag)
   );

   task automatic compare(input logic [1:0] epwr, eflg, input string tag);
      n_chk++;
      if (pwr_on !== epwr || sc_flag !== eflg || hiz_flag !== eflg) begin
         n_err++;
         $display("FAIL %s: pwr=%b sc=%b hiz=%b, expected pwr=%b sc=%b hiz=%b",
                  tag, pwr_on, sc_flag, hiz_flag, epwr, eflg, eflg);
      end
   endtask

   // Monitor: compares post-edge outputs with the queued expectation
   always @(posedge clk) begin
      #1;
      if (q.size() != 0) begin
         exp_t it;
         it = q.pop_front();
         compare(it.pwr, it.flg, it.tag);
      end
   end

   // Driver: one cycle of stimulus plus the expectation after the next edge
   task automatic step(input logic [1:0] en, det, input logic clr,
                       input logic [1:0] epwr, eflg, input string tag);
      exp_t it;
      @(negedge clk);
      ch_en = en;
      det_i = det;
      clr_i = clr;
      it.pwr = epwr;
      it.flg = eflg;
      it.tag = tag;
      q.push_back(it);
   endtask

   task automatic idle(input logic [1:0] en, input int n, input logic [1:0] flg,
                       input string tag);
      for (int i = 0; i < n; i++) step(en, 2'b00, 1'b0, en & ~flg, flg, tag);
   endtask

   // One strike on the channels in m; unless last, also the wait and re-power
   task automatic strike(input logic [1:0] en, m, flg, input bit last, input string tag);
      logic [1:0] on;
      on = en & ~flg;
      if (last) begin
         step(en, m, 1'b0, on & ~m, flg | m, tag);
      end else begin
         step(en, m, 1'b0, on & ~m, flg, tag);
         for (int i = 0; i < W - 1; i++) step(en, 2'b00, 1'b0, on & ~m, flg, tag);
         step(en, 2'b00, 1'b0, on, flg, tag);
      end
   endtask

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      compare(2'b11, 2'b00, "R1");
      ch_en = 2'b01;
      #1;
      compare(2'b01, 2'b00, "R1");
      ch_en = 2'b11;
      @(negedge clk);
      rst_n = 1'b1;

      // R2 and R11: first strike, exact wait, then clean expiry (R4)
      strike(2'b11, 2'b01, 2'b00, 0, "R11");
      idle(2'b11, N, 2'b00, "R4");
      // two strikes then expiry: count must return to zero
      strike(2'b11, 2'b01, 2'b00, 0, "R2");
      strike(2'b11, 2'b01, 2'b00, 0, "R3");
      idle(2'b11, N, 2'b00, "R4");
      // three strikes in a row latch the fault
      strike(2'b11, 2'b01, 2'b00, 0, "R4");
      strike(2'b11, 2'b01, 2'b00, 0, "R3");
      strike(2'b11, 2'b01, 2'b00, 1, "R5");

      // R6: fault persists, detections ignored
      idle(2'b11, 20, 2'b01, "R6");
      for (int i = 0; i < 3; i++) step(2'b11, 2'b01, 1'b0, 2'b10, 2'b01, "R6");

      // R9: clear together with a detection
      step(2'b11, 2'b01, 1'b1, 2'b11, 2'b00, "R9");
      idle(2'b11, 2, 2'b00, "R9");

      // R7: detection held through the whole wait is ignored
      step(2'b11, 2'b01, 1'b0, 2'b10, 2'b00, "R7");
      for (int i = 0; i < W - 1; i++) step(2'b11, 2'b01, 1'b0, 2'b10, 2'b00, "R7");
      step(2'b11, 2'b00, 1'b0, 2'b11, 2'b00, "R7");
      strike(2'b11, 2'b01, 2'b00, 0, "R7");
      idle(2'b11, N, 2'b00, "R7");

      // R8: disabled channel unpowered, detections ignored
      for (int i = 0; i < 6; i++) step(2'b10, 2'b01, 1'b0, 2'b10, 2'b00, "R8");
      step(2'b11, 2'b00, 1'b0, 2'b11, 2'b00, "R8");
      strike(2'b11, 2'b01, 2'b00, 0, "R8");
      strike(2'b11, 2'b01, 2'b00, 0, "R8");
      idle(2'b11, N, 2'b00, "R8");

      // R10: fault on channel 1 only, channel 0 keeps its own retries
      strike(2'b11, 2'b10, 2'b00, 0, "R10");
      strike(2'b11, 2'b10, 2'b00, 0, "R10");
      strike(2'b11, 2'b10, 2'b00, 1, "R10");
      strike(2'b11, 2'b01, 2'b10, 0, "R10");
      idle(2'b11, N, 2'b10, "R10");
      step(2'b11, 2'b00, 1'b1, 2'b11, 2'b00, "R6");

      // R3: detection in the last window cycle still counts
      strike(2'b11, 2'b01, 2'b00, 0, "R3");
      idle(2'b11, N - 1, 2'b00, "R3");
      strike(2'b11, 2'b01, 2'b00, 0, "R3");
      idle(2'b11, N - 1, 2'b00, "R3");
      strike(2'b11, 2'b01, 2'b00, 1, "R3");
      step(2'b11, 2'b00, 1'b1, 2'b11, 2'b00, "R6");

      // R4: detection one cycle after expiry starts a new count
      strike(2'b11, 2'b01, 2'b00, 0, "R4");
      idle(2'b11, N, 2'b00, "R4");
      strike(2'b11, 2'b01, 2'b00, 0, "R4");
      strike(2'b11, 2'b01, 2'b00, 0, "R4");
      idle(2'b11, 2, 2'b00, "R4");

      wait (q.size() == 0);
      @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule